// File: doc/BRIEF.md
# Noisy Hash Row Store

This block holds an array of wide hash words, one per row, and serves them to a separate matching engine through several parallel read lanes. Writes arrive over a valid/ready handshake with a row address and a hash word. A set fraction of accepted writes is deliberately corrupted before it reaches the array. A flip mask taken from a 128-bit xorshift generator is XORed into the word, so the stored copy differs from the written one by exactly one bit in every 64-bit group.

Whether a write is corrupted depends on a rate draw. This is a 32-bit xorshift word, reduced modulo a denominator and compared against a numerator. The mask generator steps only when a corrupted write is accepted, which keeps its sequence tied to the corruption events and not to traffic volume. Elaboration stops on an inconsistent configuration: a hash width that is not 64 times the flip count, more flips than the 128-bit state can index, a zero denominator, or a numerator above the denominator.

Top module: `noisy_hash_store`

## Requirements
- R1: While `rst` is high at a clock edge, every row is cleared to zero, the mask generator state becomes the 64-bit seed concatenated with itself, and the rate draw becomes the low 32 seed bits (or 1 when those are zero). After reset `wr_ready` is high and every lane reads zero.
- R2: A write transfers only at an edge where `wr_valid` and `wr_ready` are both high. After that edge `wr_ready` is low for exactly one cycle, and the row is written at the following edge. While valid is low, or ready is low, the row data and address inputs have no effect.
- R3: The rate draw is a 32-bit xorshift word (x ^= x<<13; x ^= x>>17; x ^= x<<5) that steps on every accepted write. A write is noisy when noise is enabled and (draw mod DEN) < NUM, with the draw value held before the step.
- R4: With the noise enable parameter cleared, every accepted write is stored exactly as written.
- R5: For a noisy write, group g (bits 64g..64g+63) has exactly one bit flipped. Its position inside the group is bits [6g+5:6g] of the 128-bit generator state, packed as {x,y,z,w} with w in bits 31:0. The state used is the one held before the write.
- R6: The generator steps as t = x^(x<<11); x,y,z take y,z,w; w = w^(w>>19)^t^(t>>8). It steps only on an accepted noisy write and holds in every other cycle.
- R7: With NUM equal to DEN, every accepted write is noisy.
- R8: Each read lane i takes its row from slice i of `rd_row_flat` and returns that row's word combinationally in slice i of `rd_hash_flat`. All lanes operate independently in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_valid | input | 1 | Write request valid |
| wr_ready | output | 1 | Store can take a write |
| wr_row | input | ROW_W | Row address of the write |
| wr_hash | input | HASH_W | Hash word to store |
| rd_row_flat | input | LANES*ROW_W | Row address per read lane, lane 0 lowest |
| rd_hash_flat | output | LANES*HASH_W | Stored word per read lane, lane 0 lowest |

## Verification
The bench drives three copies of the block side by side: one at a half rate, one with noise disabled and one with NUM equal to DEN. It compares all rows on both lanes against a model after every write. A generator that stepped on clean writes or idle cycles, or took its flip positions from the wrong state bits, would drift from the model and corrupt the wrong bits in later rows. Back-to-back requests with the data changed while ready is low show whether a design latches the second word too early or overwrites the first row. A reset issued mid-run followed by repeated writes shows whether the generator and rate draw truly return to their seeded values, and whether stale rows survive.

// File: rtl/nhs_pkg.sv
package nhs_pkg;

    localparam int GROUP_W  = 64;
    localparam int IDX_W    = 6;
    localparam int STATE_W  = 128;

    typedef struct packed {
        logic [31:0] x;
        logic [31:0] y;
        logic [31:0] z;
        logic [31:0] w;
    } xs128_t;

    function automatic xs128_t xs128_from_seed(input logic [63:0] seed);
        xs128_t s;
        s = {seed, seed};
        return s;
    endfunction

    function automatic xs128_t xs128_next(input xs128_t s);
        xs128_t n;
        logic [31:0] t;
        t   = s.x ^ (s.x << 11);
        n.x = s.y;
        n.y = s.z;
        n.z = s.w;
        n.w = s.w ^ (s.w >> 19) ^ t ^ (t >> 8);
        return n;
    endfunction

    function automatic logic [31:0] xs32_from_seed(input logic [31:0] seed);
        return (seed == 32'd0) ? 32'd1 : seed;
    endfunction

    function automatic logic [31:0] xs32_next(input logic [31:0] v);
        logic [31:0] a;
        a = v ^ (v << 13);
        a = a ^ (a >> 17);
        a = a ^ (a << 5);
        return a;
    endfunction

endpackage

// File: rtl/nhs_rate_draw.sv
module nhs_rate_draw
    import nhs_pkg::*;
#(
    parameter bit          NOISE_ON = 1'b1,
    parameter int          RATE_NUM = 1,
    parameter int          RATE_DEN = 100,
    parameter logic [63:0] SEED     = 64'hB504_F32D_B504_F32D
) (
    input  logic clk,
    input  logic rst,
    input  logic step,
    output logic noisy
);

    if (RATE_DEN <= 0) begin : g_bad_den
        $error("nhs_rate_draw: denominator must be positive");
    end
    if (RATE_NUM < 0 || RATE_NUM > RATE_DEN) begin : g_bad_num
        $error("nhs_rate_draw: numerator must lie in 0..denominator");
    end

    localparam logic [31:0] DEN_U = 32'(RATE_DEN);
    localparam logic [31:0] NUM_U = 32'(RATE_NUM);

    logic [31:0] draw_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            draw_q <= xs32_from_seed(SEED[31:0]);
        end else if (step) begin
            draw_q <= xs32_next(draw_q);
        end
    end

    if (NOISE_ON) begin : g_on
        assign noisy = (draw_q % DEN_U) < NUM_U;
    end else begin : g_off
        assign noisy = 1'b0;
    end

endmodule

// File: rtl/nhs_flip_gen.sv
module nhs_flip_gen
    import nhs_pkg::*;
#(
    parameter int          FLIPS  = 8,
    parameter int          HASH_W = 512,
    parameter logic [63:0] SEED   = 64'hB504_F32D_B504_F32D
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               advance,
    output logic [STATE_W-1:0] state,
    output logic [HASH_W-1:0]  flip_mask
);

    if (FLIPS < 1 || HASH_W != FLIPS * GROUP_W) begin : g_bad_width
        $error("nhs_flip_gen: hash width must be 64 times the flip count");
    end
    if (FLIPS * IDX_W > STATE_W) begin : g_bad_flips
        $error("nhs_flip_gen: too many flips for the generator state");
    end

    xs128_t st_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= xs128_from_seed(SEED);
        end else if (advance) begin
            st_q <= xs128_next(st_q);
        end
    end

    assign state = st_q;

    for (genvar g = 0; g < FLIPS; g++) begin : g_group
        logic [IDX_W-1:0]   pos;
        logic [GROUP_W-1:0] one_hot;
        assign pos     = state[g*IDX_W +: IDX_W];
        assign one_hot = GROUP_W'(1) << pos;
        assign flip_mask[g*GROUP_W +: GROUP_W] = one_hot;
    end

endmodule

// File: rtl/nhs_write_stage.sv
module nhs_write_stage #(
    parameter int ROW_W  = 4,
    parameter int HASH_W = 512
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_valid,
    output logic              wr_ready,
    input  logic [ROW_W-1:0]  wr_row,
    input  logic [HASH_W-1:0] wr_hash,
    input  logic              noisy,
    input  logic [HASH_W-1:0] flip_mask,
    output logic              accept,
    output logic              we,
    output logic [ROW_W-1:0]  we_row,
    output logic [HASH_W-1:0] we_data
);

    typedef struct packed {
        logic              busy;
        logic [ROW_W-1:0]  row;
        logic [HASH_W-1:0] data;
    } pend_t;

    pend_t pend_q;
    logic [HASH_W-1:0] shaped;

    assign wr_ready = !pend_q.busy;
    assign accept   = wr_valid && wr_ready;
    assign shaped   = noisy ? (wr_hash ^ flip_mask) : wr_hash;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= '0;
        end else if (accept) begin
            pend_q.busy <= 1'b1;
            pend_q.row  <= wr_row;
            pend_q.data <= shaped;
        end else begin
            pend_q.busy <= 1'b0;
        end
    end

    assign we      = pend_q.busy;
    assign we_row  = pend_q.row;
    assign we_data = pend_q.data;

endmodule

// File: rtl/nhs_row_bank.sv
module nhs_row_bank #(
    parameter int ROWS   = 16,
    parameter int LANES  = 4,
    parameter int ROW_W  = 4,
    parameter int HASH_W = 512
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    we,
    input  logic [ROW_W-1:0]        we_row,
    input  logic [HASH_W-1:0]       we_data,
    input  logic [LANES*ROW_W-1:0]  rd_row_flat,
    output logic [LANES*HASH_W-1:0] rd_hash_flat
);

    logic [HASH_W-1:0] rows_q [ROWS];

    for (genvar r = 0; r < ROWS; r++) begin : g_row
        always_ff @(posedge clk) begin
            if (rst) begin
                rows_q[r] <= '0;
            end else if (we && we_row == ROW_W'(r)) begin
                rows_q[r] <= we_data;
            end
        end
    end

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        logic [ROW_W-1:0] sel;
        assign sel = rd_row_flat[l*ROW_W +: ROW_W];
        always_comb begin
            rd_hash_flat[l*HASH_W +: HASH_W] = '0;
            if (32'(sel) < ROWS) begin
                rd_hash_flat[l*HASH_W +: HASH_W] = rows_q[sel];
            end
        end
    end

endmodule

// File: rtl/noisy_hash_store.sv
module noisy_hash_store
    import nhs_pkg::*;
#(
    parameter int          ROWS     = 16,
    parameter int          LANES    = 4,
    parameter int          FLIPS    = 8,
    parameter int          HASH_W   = FLIPS * 64,
    parameter bit          NOISE_ON = 1'b1,
    parameter int          RATE_NUM = 1,
    parameter int          RATE_DEN = 100,
    parameter logic [63:0] SEED     = 64'hB504_F32D_B504_F32D,
    localparam int         ROW_W    = (ROWS > 1) ? $clog2(ROWS) : 1
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    wr_valid,
    output logic                    wr_ready,
    input  logic [ROW_W-1:0]        wr_row,
    input  logic [HASH_W-1:0]       wr_hash,
    input  logic [LANES*ROW_W-1:0]  rd_row_flat,
    output logic [LANES*HASH_W-1:0] rd_hash_flat
);

    logic               accept;
    logic               noisy;
    logic [STATE_W-1:0] prng_state;
    logic [HASH_W-1:0]  flip_mask;
    logic               we;
    logic [ROW_W-1:0]   we_row;
    logic [HASH_W-1:0]  we_data;

    nhs_rate_draw #(
        .NOISE_ON (NOISE_ON),
        .RATE_NUM (RATE_NUM),
        .RATE_DEN (RATE_DEN),
        .SEED     (SEED)
    ) u_rate (
        .clk   (clk),
        .rst   (rst),
        .step  (accept),
        .noisy (noisy)
    );

    nhs_flip_gen #(
        .FLIPS  (FLIPS),
        .HASH_W (HASH_W),
        .SEED   (SEED)
    ) u_flip (
        .clk       (clk),
        .rst       (rst),
        .advance   (accept && noisy),
        .state     (prng_state),
        .flip_mask (flip_mask)
    );

    nhs_write_stage #(
        .ROW_W  (ROW_W),
        .HASH_W (HASH_W)
    ) u_wr (
        .clk       (clk),
        .rst       (rst),
        .wr_valid  (wr_valid),
        .wr_ready  (wr_ready),
        .wr_row    (wr_row),
        .wr_hash   (wr_hash),
        .noisy     (noisy),
        .flip_mask (flip_mask),
        .accept    (accept),
        .we        (we),
        .we_row    (we_row),
        .we_data   (we_data)
    );

    nhs_row_bank #(
        .ROWS   (ROWS),
        .LANES  (LANES),
        .ROW_W  (ROW_W),
        .HASH_W (HASH_W)
    ) u_bank (
        .clk          (clk),
        .rst          (rst),
        .we           (we),
        .we_row       (we_row),
        .we_data      (we_data),
        .rd_row_flat  (rd_row_flat),
        .rd_hash_flat (rd_hash_flat)
    );

endmodule

// File: rtl/nhs_checker.sv
module nhs_checker #(
    parameter int ROW_W  = 4,
    parameter int HASH_W = 512,
    parameter int FLIPS  = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              wr_valid,
    input logic              wr_ready,
    input logic [ROW_W-1:0]  wr_row,
    input logic              accept,
    input logic              noisy,
    input logic [127:0]      prng_state,
    input logic [HASH_W-1:0] flip_mask,
    input logic              we,
    input logic [ROW_W-1:0]  we_row
);

    // R2: an accepted write drops ready and raises the array write next cycle
    p_ready_drop_r2: assert property (@(posedge clk) disable iff (rst)
        (wr_valid && wr_ready) |=> (!wr_ready && we));

    // R2: ready comes back after one busy cycle
    p_ready_back_r2: assert property (@(posedge clk) disable iff (rst)
        !wr_ready |=> wr_ready);

    // R2: the array writes the row that was presented at acceptance
    p_row_target_r2: assert property (@(posedge clk) disable iff (rst)
        (wr_valid && wr_ready) |=> (we_row == $past(wr_row)));

    // R5: the mask carries one set bit per 64-bit group
    p_mask_weight_r5: assert property (@(posedge clk) disable iff (rst)
        accept |-> ($countones(flip_mask) == FLIPS));

    // R6: the generator holds unless a noisy write is accepted
    p_prng_hold_r6: assert property (@(posedge clk) disable iff (rst)
        !(accept && noisy) |=> $stable(prng_state));

    // R6: an accepted noisy write moves the generator
    p_prng_move_r6: assert property (@(posedge clk) disable iff (rst)
        (accept && noisy) |=> (prng_state != $past(prng_state)));

endmodule

bind noisy_hash_store nhs_checker #(
    .ROW_W  (ROW_W),
    .HASH_W (HASH_W),
    .FLIPS  (FLIPS)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .wr_valid   (wr_valid),
    .wr_ready   (wr_ready),
    .wr_row     (wr_row),
    .accept     (accept),
    .noisy      (noisy),
    .prng_state (prng_state),
    .flip_mask  (flip_mask),
    .we         (we),
    .we_row     (we_row)
);

// File: tb/sim_noisy_hash_store.sv
`timescale 1ns/1ps
module sim_noisy_hash_store;

    localparam int NR = 8;
    localparam int NL = 2;
    localparam int RW = 3;
    localparam int HW = 128;
    localparam int NI = 3;
    localparam logic [63:0] SD = 64'hB504_F32D_B504_F32D;

    // instance 0: half rate, 1: noise off, 2: every write noisy
    localparam bit IEN [NI] = '{1'b1, 1'b0, 1'b1};
    localparam int INUM[NI] = '{1, 1, 1};
    localparam int IDEN[NI] = '{2, 2, 1};

    localparam int NV = 10;
    localparam logic [66:0] VEC [NV] = '{
        {3'd0, 64'h0123_4567_89AB_CDEF},
        {3'd5, 64'hFFFF_FFFF_FFFF_FFFF},
        {3'd2, 64'h0000_0000_0000_0000},
        {3'd7, 64'hDEAD_BEEF_CAFE_F00D},
        {3'd5, 64'h8000_0000_0000_0001},
        {3'd1, 64'h5555_AAAA_5555_AAAA},
        {3'd3, 64'h0F0F_0F0F_F0F0_F0F0},
        {3'd6, 64'h1357_9BDF_2468_ACE0},
        {3'd4, 64'h7FFF_0000_FFFF_0001},
        {3'd0, 64'hA5A5_5A5A_C3C3_3C3C}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic wr_valid = 1'b0;
    logic [RW-1:0] wr_row = '0;
    logic [HW-1:0] wr_hash = '0;
    logic [NL*RW-1:0] rd_row_flat = '0;
    logic [NI-1:0] rdy;
    logic [NL*HW-1:0] rh [NI];

    always #4 clk = ~clk;

    noisy_hash_store #(.ROWS(NR), .LANES(NL), .FLIPS(2), .NOISE_ON(1'b1),
        .RATE_NUM(1), .RATE_DEN(2), .SEED(SD)) u0 (
        .clk(clk), .rst(rst), .wr_valid(wr_valid), .wr_ready(rdy[0]),
        .wr_row(wr_row), .wr_hash(wr_hash), .rd_row_flat(rd_row_flat),
        .rd_hash_flat(rh[0]));

    noisy_hash_store #(.ROWS(NR), .LANES(NL), .FLIPS(2), .NOISE_ON(1'b0),
        .RATE_NUM(1), .RATE_DEN(2), .SEED(SD)) u1 (
        .clk(clk), .rst(rst), .wr_valid(wr_valid), .wr_ready(rdy[1]),
        .wr_row(wr_row), .wr_hash(wr_hash), .rd_row_flat(rd_row_flat),
        .rd_hash_flat(rh[1]));

    noisy_hash_store #(.ROWS(NR), .LANES(NL), .FLIPS(2), .NOISE_ON(1'b1),
        .RATE_NUM(1), .RATE_DEN(1), .SEED(SD)) u2 (
        .clk(clk), .rst(rst), .wr_valid(wr_valid), .wr_ready(rdy[2]),
        .wr_row(wr_row), .wr_hash(wr_hash), .rd_row_flat(rd_row_flat),
        .rd_hash_flat(rh[2]));

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    logic [31:0]   m_draw [NI];
    logic [127:0]  m_st   [NI];
    logic [HW-1:0] m_mem  [NI][NR];
    int            m_noisy[NI];

    function automatic logic [127:0] b_step(input logic [127:0] s);
        logic [31:0] a, b, c, d, t;
        a = s[127:96]; b = s[95:64]; c = s[63:32]; d = s[31:0];
        t = a ^ (a << 11);
        return {b, c, d, d ^ (d >> 19) ^ t ^ (t >> 8)};
    endfunction

    function automatic logic [31:0] b_draw_step(input logic [31:0] v);
        logic [31:0] q;
        q = v ^ (v << 13);
        q = q ^ (q >> 17);
        q = q ^ (q << 5);
        return q;
    endfunction

    function automatic logic [HW-1:0] b_mask(input logic [127:0] s);
        logic [HW-1:0] m;
        m = '0;
        for (int g = 0; g < 2; g++) m[g*64 + int'(s[g*6 +: 6])] = 1'b1;
        return m;
    endfunction

    task automatic model_reset();
        for (int k = 0; k < NI; k++) begin
            m_draw[k] = (SD[31:0] == 32'd0) ? 32'd1 : SD[31:0];
            m_st[k]   = {SD, SD};
            for (int r = 0; r < NR; r++) m_mem[k][r] = '0;
        end
    endtask

    task automatic model_write(input logic [RW-1:0] row, input logic [HW-1:0] h);
        for (int k = 0; k < NI; k++) begin
            bit nz;
            nz = IEN[k] && ((m_draw[k] % 32'(IDEN[k])) < 32'(INUM[k]));
            if (nz) begin
                m_mem[k][row] = h ^ b_mask(m_st[k]);
                m_st[k] = b_step(m_st[k]);
                m_noisy[k]++;
            end else begin
                m_mem[k][row] = h;
            end
            m_draw[k] = b_draw_step(m_draw[k]);
        end
    endtask

    task automatic chk(input bit ok, input string req,
                       input logic [HW-1:0] act, input logic [HW-1:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic check_ready(input logic v, input string req);
        for (int k = 0; k < NI; k++)
            chk(rdy[k] == v, req, HW'(rdy[k]), HW'(v));
    endtask

    // all rows on both lanes, lane 1 reads the mirrored row (R8)
    task automatic check_rows(input string req);
        for (int r = 0; r < NR; r++) begin
            rd_row_flat = {RW'(NR - 1 - r), RW'(r)};
            #0.2;
            for (int k = 0; k < NI; k++) begin
                chk(rh[k][HW-1:0] == m_mem[k][r], req, rh[k][HW-1:0], m_mem[k][r]);
                chk(rh[k][2*HW-1:HW] == m_mem[k][NR-1-r], "R8 lane1",
                    rh[k][2*HW-1:HW], m_mem[k][NR-1-r]);
            end
        end
    endtask

    task automatic do_write(input logic [RW-1:0] row, input logic [HW-1:0] h);
        wr_valid = 1'b1; wr_row = row; wr_hash = h;
        while (!rdy[0]) @(negedge clk);
        @(negedge clk);
        model_write(row, h);
        wr_valid = 1'b0;
        wr_hash = ~h;
        check_ready(1'b0, "R2 busy after accept");
        @(negedge clk);
        check_ready(1'b1, "R2 ready again");
        // R5: exactly one bit per group in the always-noisy copy
        rd_row_flat = {RW'(0), row};
        #0.2;
        for (int g = 0; g < 2; g++) begin
            logic [63:0] d;
            d = rh[2][g*64 +: 64] ^ h[g*64 +: 64];
            chk($countones(d) == 1, "R5 one flip per group", HW'($countones(d)), HW'(1));
        end
        // R4: noise-off copy keeps the word
        chk(rh[1][HW-1:0] == h, "R4 exact store", rh[1][HW-1:0], h);
        check_rows("R3 R6 R7 row contents");
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        for (int k = 0; k < NI; k++) m_noisy[k] = 0;
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1: reset state
        check_ready(1'b1, "R1 ready after reset");
        check_rows("R1 rows zero after reset");

        // table walk
        for (int i = 0; i < NV; i++) begin
            logic [63:0] p;
            p = VEC[i][63:0];
            do_write(VEC[i][66:64], {p, p ^ 64'hFFFF_0000_FFFF_0000});
        end
        // R7: every write to the full-rate copy was noisy
        chk(m_noisy[2] == NV, "R7 all noisy", HW'(m_noisy[2]), HW'(NV));

        // R2: idle cycles with garbage on the data inputs change nothing
        @(negedge clk);
        for (int i = 0; i < 5; i++) begin
            wr_row = RW'(i); wr_hash = {4{32'hBADC_0DE0 + 32'(i)}};
            @(negedge clk);
        end
        check_rows("R2 idle no effect");
        do_write(3'd2, {2{64'h0BAD_F00D_1234_5678}});

        // R2: back-to-back, data changed while ready is low
        wr_valid = 1'b1; wr_row = 3'd6; wr_hash = {2{64'h1111_2222_3333_4444}};
        @(negedge clk);
        model_write(3'd6, {2{64'h1111_2222_3333_4444}});
        check_ready(1'b0, "R2 b2b busy");
        wr_row = 3'd1; wr_hash = {2{64'h9999_8888_7777_6666}};
        @(negedge clk);
        check_ready(1'b1, "R2 b2b ready");
        check_rows("R2 first word kept while busy");
        @(negedge clk);
        model_write(3'd1, {2{64'h9999_8888_7777_6666}});
        wr_valid = 1'b0;
        @(negedge clk);
        check_rows("R2 second word after ready");

        // R1: mid-run reset reseeds and clears
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        model_reset();
        check_ready(1'b1, "R1 ready after second reset");
        check_rows("R1 rows cleared by reset");
        for (int i = 0; i < 3; i++) begin
            logic [63:0] p;
            p = VEC[i][63:0];
            do_write(VEC[i][66:64], {p, p ^ 64'hFFFF_0000_FFFF_0000});
        end

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule